// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetch Engine

This block moves frame-buffer contents from memory toward a display pipeline. Memory holds a chain of descriptors. Each descriptor is four 32-bit words. One field points to the next descriptor, one gives the source address of the data, and one command word holds the transfer length and a palette flag. The engine walks this chain. It reads each payload in bursts whose size can be chosen, and it sends frame words into an internal pixel FIFO. Palette words go out on a separate write port, where a lookup table outside this block can pick them up.

Software loads the address of the first descriptor through a simple write strobe. After that, the display timing generator sets the pace with a frame-start pulse. A frame descriptor is fetched only at a frame start. A palette descriptor is followed at once by the descriptor it links to, so a palette and a frame can share one frame period. A descriptor whose link points at itself replays the same frame every period, and the engine does not read that descriptor again. The display side takes pixels one at a time with a pop strobe. A pop that finds the FIFO empty is an underrun. It sets a flag that stays set until the next address load, and the pixel value on that pop is either held or forced to zero.

Top module: `frame_fetch_engine`

## Requirements
- R1: A descriptor is fetched as a single 4-word read at its address. The words are, in order: link address, source address, an identifier that is not used, and the command. Command bits [23:0] give the payload length in 32-bit words, and command bit 28 set marks a palette payload.
- R2: A `start_wr` pulse in the idle or waiting state loads `start_addr` as the next descriptor, empties the pixel FIFO and clears `underrun`. No memory request is issued until `frame_start` is seen.
- R3: Frame payload words reach `pix_data` in memory order. Each pop of a non-empty FIFO shows the next word on `pix_data` one cycle after `pix_pop`.
- R4: Payload reads are split into bursts of 4, 8 or 16 words for `burst_sel` 0, 1 or 2. The last burst of a payload carries the remainder. Each burst address is 4 bytes per word past the previous one.
- R5: A frame burst is requested only when the FIFO has free room for the whole burst, so the engine stalls rather than overflows.
- R6: Palette payload words appear on `pal_data` with `pal_we` high, with `pal_idx` counting up from 0. They never enter the pixel FIFO. The linked descriptor is fetched straight away, without waiting for `frame_start`.
- R7: When a frame payload finishes, the linked descriptor is not fetched until the next `frame_start`.
- R8: If a frame descriptor links to its own address, each later `frame_start` replays the same payload without reading the descriptor again.
- R9: A descriptor of length zero reads no payload, and the engine moves on along the chain.
- R10: A pop on an empty FIFO leaves `pix_data` unchanged when `underrun_protect` is 1 and sets it to zero when `underrun_protect` is 0.
- R11: `underrun` goes high on the first pop of an empty FIFO and stays high until a `start_wr` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_wr | input | 1 | Load strobe for the first descriptor address |
| start_addr | input | 32 | Byte address of the first descriptor |
| frame_start | input | 1 | One-cycle pulse at the start of each display frame |
| burst_sel | input | 2 | Payload burst size: 0=4, 1=8, 2=16 words |
| underrun_protect | input | 1 | Hold the last pixel on underrun instead of sending zero |
| mem_req | output | 1 | Read request, held until accepted |
| mem_addr | output | 32 | Byte address of the read |
| mem_len | output | 5 | Number of words in the read |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data word valid |
| mem_rdata | input | 32 | Read data word |
| pix_pop | input | 1 | Display takes one pixel word |
| pix_data | output | 32 | Current pixel word |
| pix_avail | output | 1 | Pixel FIFO holds at least one word |
| pal_we | output | 1 | Palette word valid |
| pal_idx | output | 8 | Word index within the palette payload |
| pal_data | output | 32 | Palette word |
| underrun | output | 1 | Sticky underrun flag |

## Verification
Internal faults in this engine show up mostly in the read request log and the pixel stream, one or two cycles after the step that went wrong. A descriptor word stored in the wrong register shows as a wrong burst address on the next request. A miscounted remainder shows as a wrong length on the final burst of a payload. A lost self-link flag shows as an extra 4-word read at the descriptor address in the next frame. A stuck wait state shows as no request after `frame_start`. A bad FIFO pointer shows as a wrong word on `pix_data` on the very next pop.

// File: rtl/ffe_pkg.sv
// Package: shared constants, state encoding and burst-size decode for the
// frame fetch engine. Assumes 32-bit memory words.
package ffe_pkg;
    localparam int WORD_W      = 32;
    localparam int CMD_LEN_W   = 24;
    localparam int CMD_PAL_BIT = 28;
    localparam int DESC_WORDS  = 4;
    localparam int BLEN_W      = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DREQ,
        ST_DDATA,
        ST_XCHK,
        ST_XREQ,
        ST_XDATA
    } fetch_state_t;

    // Burst size in words for a selector code; codes above 2 give the largest.
    function automatic logic [BLEN_W-1:0] burst_words(input logic [1:0] sel);
        case (sel)
            2'd0:    burst_words = BLEN_W'(4);
            2'd1:    burst_words = BLEN_W'(8);
            default: burst_words = BLEN_W'(16);
        endcase
    endfunction
endpackage

// File: rtl/ffe_fifo.sv
// Synchronous first-word-fall-through FIFO for pixel words.
// Assumes DEPTH is a power of two; flush empties it in one cycle.
module ffe_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] free
);
    logic [W-1:0]  store [DEPTH];
    logic [CW-1:0] wp, rp;
    logic [CW-1:0] used;

    assign used  = wp - rp;
    assign empty = (used == '0);
    assign full  = (used == CW'(DEPTH));
    assign free  = CW'(DEPTH) - used;
    assign rdata = store[rp[AW-1:0]];

    // Pointer update: flush wins, otherwise advance on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) store[wp[AW-1:0]] <= wdata;
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
endmodule

// File: rtl/ffe_desc_ctrl.sv
// Descriptor walker: fetches 4-word descriptors, issues payload bursts and
// steers payload words to the pixel FIFO or the palette port.
// Assumes one outstanding read and in-order read data.
module ffe_desc_ctrl
    import ffe_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int FREE_W    = 6,
    parameter int PAL_IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_wr,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic                 frame_start,
    input  logic [1:0]           burst_sel,
    output logic                 load_ok,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BLEN_W-1:0]    mem_len,
    input  logic                 mem_ack,
    input  logic                 mem_rvalid,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic [FREE_W-1:0]    fifo_free,
    output logic                 fifo_push,
    output logic [WORD_W-1:0]    fifo_wdata,
    output logic                 pal_we,
    output logic [PAL_IDX_W-1:0] pal_idx,
    output logic [WORD_W-1:0]    pal_data
);
    localparam int LW = CMD_LEN_W;

    fetch_state_t      state;
    logic [ADDR_W-1:0] desc_addr, link_addr, src_addr, rd_addr;
    logic [LW-1:0]     cmd_len, rem, word_idx;
    logic              cmd_pal, reuse;
    logic [1:0]        dw_cnt;
    logic [BLEN_W-1:0] req_len, beat, bw, next_len;

    assign bw      = burst_words(burst_sel);
    assign load_ok = start_wr && (state == ST_IDLE || state == ST_WAIT);

    // Next burst length: selected size, or the remainder when smaller.
    always_comb begin
        if (rem < LW'(bw)) next_len = rem[BLEN_W-1:0];
        else               next_len = bw;
    end

    // Walker state machine with descriptor and payload bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            desc_addr <= '0;
            link_addr <= '0;
            src_addr  <= '0;
            rd_addr   <= '0;
            cmd_len   <= '0;
            cmd_pal   <= 1'b0;
            rem       <= '0;
            word_idx  <= '0;
            reuse     <= 1'b0;
            dw_cnt    <= '0;
            req_len   <= '0;
            beat      <= '0;
        end else if (load_ok) begin
            desc_addr <= start_addr;
            reuse     <= 1'b0;
            state     <= ST_WAIT;
        end else begin
            case (state)
                ST_WAIT: begin
                    if (frame_start) begin
                        if (reuse) begin
                            rd_addr  <= src_addr;
                            rem      <= cmd_len;
                            word_idx <= '0;
                            state    <= ST_XCHK;
                        end else begin
                            state <= ST_DREQ;
                        end
                    end
                end
                ST_DREQ: begin
                    if (mem_ack) begin
                        dw_cnt <= '0;
                        state  <= ST_DDATA;
                    end
                end
                ST_DDATA: begin
                    if (mem_rvalid) begin
                        dw_cnt <= dw_cnt + 1'b1;
                        case (dw_cnt)
                            2'd0: link_addr <= mem_rdata[ADDR_W-1:0];
                            2'd1: src_addr  <= mem_rdata[ADDR_W-1:0];
                            2'd3: begin
                                cmd_len  <= mem_rdata[LW-1:0];
                                cmd_pal  <= mem_rdata[CMD_PAL_BIT];
                                rem      <= mem_rdata[LW-1:0];
                                rd_addr  <= src_addr;
                                word_idx <= '0;
                                state    <= ST_XCHK;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_XCHK: begin
                    if (rem == '0) begin
                        desc_addr <= link_addr;
                        if (cmd_pal) begin
                            reuse <= 1'b0;
                            state <= ST_DREQ;
                        end else begin
                            reuse <= (link_addr == desc_addr);
                            state <= ST_WAIT;
                        end
                    end else if (cmd_pal || fifo_free >= FREE_W'(next_len)) begin
                        req_len <= next_len;
                        state   <= ST_XREQ;
                    end
                end
                ST_XREQ: begin
                    if (mem_ack) begin
                        beat  <= '0;
                        state <= ST_XDATA;
                    end
                end
                ST_XDATA: begin
                    if (mem_rvalid) begin
                        beat     <= beat + 1'b1;
                        word_idx <= word_idx + 1'b1;
                        if (beat == req_len - 1'b1) begin
                            rd_addr <= rd_addr + ADDR_W'({req_len, 2'b00});
                            rem     <= rem - LW'(req_len);
                            state   <= ST_XCHK;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Request port and payload steering.
    always_comb begin
        mem_req    = (state == ST_DREQ) || (state == ST_XREQ);
        mem_addr   = (state == ST_DREQ) ? desc_addr : rd_addr;
        mem_len    = (state == ST_DREQ) ? BLEN_W'(DESC_WORDS) : req_len;
        fifo_push  = (state == ST_XDATA) && mem_rvalid && !cmd_pal;
        fifo_wdata = mem_rdata;
        pal_we     = (state == ST_XDATA) && mem_rvalid && cmd_pal;
        pal_idx    = word_idx[PAL_IDX_W-1:0];
        pal_data   = mem_rdata;
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));

    assert_burst_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XREQ) |-> (mem_len != '0 && mem_len <= bw));

    assert_data_expected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> (state == ST_DDATA || state == ST_XDATA));
endmodule

// File: rtl/ffe_pix_out.sv
// Pixel output stage: pops the FIFO on request, registers the pixel and
// handles underrun (hold or zero) with a sticky flag cleared by clear.
module ffe_pix_out #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         pix_pop,
    input  logic         protect_en,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_rdata,
    output logic         fifo_pop,
    output logic [W-1:0] pix_data,
    output logic         underrun
);
    logic starve;

    assign starve   = pix_pop && fifo_empty;
    assign fifo_pop = pix_pop && !fifo_empty;

    // Pixel register: next word, held word, or zero fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_data <= '0;
        end else if (fifo_pop) begin
            pix_data <= fifo_rdata;
        end else if (starve && !protect_en) begin
            pix_data <= '0;
        end
    end

    // Sticky underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) underrun <= 1'b0;
        else if (starve)     underrun <= 1'b1;
    end

    assert_hold_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_pop && fifo_empty && protect_en) |=> $stable(pix_data));

    assert_zero_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_pop && fifo_empty && !protect_en) |=> (pix_data == '0));

    assert_sticky_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !clear) |=> underrun);
endmodule

// File: rtl/frame_fetch_engine.sv
// Top of the descriptor-chained frame fetch engine: walker, pixel FIFO and
// output stage. Assumes FIFO_DEPTH is a power of two and at least 16.
module frame_fetch_engine #(
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 32,
    parameter int PAL_IDX_W  = 8,
    localparam int FREE_W    = $clog2(FIFO_DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_wr,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic                 frame_start,
    input  logic [1:0]           burst_sel,
    input  logic                 underrun_protect,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [4:0]           mem_len,
    input  logic                 mem_ack,
    input  logic                 mem_rvalid,
    input  logic [31:0]          mem_rdata,
    input  logic                 pix_pop,
    output logic [31:0]          pix_data,
    output logic                 pix_avail,
    output logic                 pal_we,
    output logic [PAL_IDX_W-1:0] pal_idx,
    output logic [31:0]          pal_data,
    output logic                 underrun
);
    logic              load_ok;
    logic              f_push, f_pop, f_empty, f_full;
    logic [31:0]       f_wdata, f_rdata;
    logic [FREE_W-1:0] f_free;

    ffe_desc_ctrl #(
        .ADDR_W    (ADDR_W),
        .FREE_W    (FREE_W),
        .PAL_IDX_W (PAL_IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_wr    (start_wr),
        .start_addr  (start_addr),
        .frame_start (frame_start),
        .burst_sel   (burst_sel),
        .load_ok     (load_ok),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_len     (mem_len),
        .mem_ack     (mem_ack),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .fifo_free   (f_free),
        .fifo_push   (f_push),
        .fifo_wdata  (f_wdata),
        .pal_we      (pal_we),
        .pal_idx     (pal_idx),
        .pal_data    (pal_data)
    );

    ffe_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (32)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (load_ok),
        .push  (f_push),
        .wdata (f_wdata),
        .pop   (f_pop),
        .rdata (f_rdata),
        .empty (f_empty),
        .full  (f_full),
        .free  (f_free)
    );

    ffe_pix_out #(
        .W (32)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (load_ok),
        .pix_pop    (pix_pop),
        .protect_en (underrun_protect),
        .fifo_empty (f_empty),
        .fifo_rdata (f_rdata),
        .fifo_pop   (f_pop),
        .pix_data   (pix_data),
        .underrun   (underrun)
    );

    assign pix_avail = !f_empty;

    assert_full_blocks_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        f_full |-> !f_push);
endmodule

// File: tb/frame_fetch_engine_tb.sv
module frame_fetch_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_wr = 1'b0;
    logic [31:0] start_addr = '0;
    logic        frame_start = 1'b0;
    logic [1:0]  burst_sel = 2'd0;
    logic        underrun_protect = 1'b1;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_len;
    logic        mem_ack;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        pix_pop = 1'b0;
    logic [31:0] pix_data;
    logic        pix_avail;
    logic        pal_we;
    logic [7:0]  pal_idx;
    logic [31:0] pal_data;
    logic        underrun;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_fetch_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_addr(start_addr),
        .frame_start(frame_start), .burst_sel(burst_sel),
        .underrun_protect(underrun_protect), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .pix_pop(pix_pop), .pix_data(pix_data),
        .pix_avail(pix_avail), .pal_we(pal_we), .pal_idx(pal_idx),
        .pal_data(pal_data), .underrun(underrun)
    );

    // Memory model: accepts one request, then streams its words; logs grants.
    logic [31:0] mem [1024];
    logic [9:0]  ptr;
    logic [4:0]  left;
    logic [31:0] g_addr [64];
    logic [4:0]  g_len  [64];
    int          g_n;
    logic [7:0]  p_idx  [16];
    logic [31:0] p_data [16];
    int          p_n;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack    <= 1'b0;
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            left       <= '0;
            ptr        <= '0;
            g_n        <= 0;
            p_n        <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (left != 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[ptr];
                ptr        <= ptr + 1'b1;
                left       <= left - 1'b1;
            end else begin
                mem_rvalid <= 1'b0;
            end
            if (mem_req && !mem_ack && left == 0) begin
                mem_ack <= 1'b1;
                ptr     <= mem_addr[11:2];
                left    <= mem_len;
                if (g_n < 64) begin
                    g_addr[g_n] <= mem_addr;
                    g_len[g_n]  <= mem_len;
                end
                g_n <= g_n + 1;
            end
            if (pal_we) begin
                if (p_n < 16) begin
                    p_idx[p_n]  <= pal_idx;
                    p_data[p_n] <= pal_data;
                end
                p_n <= p_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic put(input int addr, input logic [31:0] val);
        mem[addr >> 2] = val;
    endtask

    task automatic put_desc(input int at, input int link, input int src,
                            input logic [31:0] cmd);
        put(at, link); put(at + 4, src); put(at + 8, 32'h5A); put(at + 12, cmd);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int addr);
        @(negedge clk); start_addr = addr; start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic pop_word(output logic [31:0] v);
        @(negedge clk); pix_pop = 1'b1;
        @(negedge clk); pix_pop = 1'b0;
        v = pix_data;
    endtask

    task automatic chk_grant(input int k, input int addr, input int len, input string req);
        chk(g_addr[k] == 32'(addr), req, $sformatf("grant %0d address", k), g_addr[k], addr);
        chk(g_len[k] == 5'(len), req, $sformatf("grant %0d length", k), 32'(g_len[k]), len);
    endtask

    task automatic pop_and_compare(input int n, input logic [31:0] base, input string req);
        logic [31:0] v;
        int bad = 0;
        logic [31:0] first_bad_a = '0, first_bad_e = '0;
        for (int i = 0; i < n; i++) begin
            pop_word(v);
            if (v != base + 32'(i) && bad == 0) begin
                first_bad_a = v; first_bad_e = base + 32'(i);
            end
            if (v != base + 32'(i)) bad++;
        end
        chk(bad == 0, req, "pixel stream order", first_bad_a, first_bad_e);
    endtask

    // Reset state of the ports.
    task automatic t_reset();
        chk(mem_req == 1'b0, "R2", "mem_req after reset", 32'(mem_req), 0);
        chk(pix_data == '0, "R3", "pix_data after reset", pix_data, 0);
        chk(pix_avail == 1'b0, "R3", "pix_avail after reset", 32'(pix_avail), 0);
        chk(underrun == 1'b0, "R11", "underrun after reset", 32'(underrun), 0);
    endtask

    // Self-linked true-colour descriptor, 4-word bursts, 10-word payload.
    task automatic t_self_link();
        int b;
        burst_sel = 2'd0;
        b = g_n;
        load(32'h100);
        cycles(20);
        chk(g_n == b, "R2", "requests before frame start", 32'(g_n - b), 0);
        pulse_frame();
        cycles(300);
        chk(g_n - b == 4, "R4", "grant count first frame", 32'(g_n - b), 4);
        chk_grant(b, 32'h100, 4, "R1");
        chk_grant(b + 1, 32'h400, 4, "R4");
        chk_grant(b + 2, 32'h410, 4, "R4");
        chk_grant(b + 3, 32'h420, 2, "R4");
        pop_and_compare(10, 32'hA000, "R3");
        chk(underrun == 1'b0, "R11", "no underrun on normal pops", 32'(underrun), 0);
        b = g_n;
        pulse_frame();
        cycles(300);
        chk(g_n - b == 3, "R8", "grant count replayed frame", 32'(g_n - b), 3);
        chk_grant(b, 32'h400, 4, "R8");
        pop_and_compare(10, 32'hA000, "R8");
    endtask

    // Palette descriptor followed by a frame descriptor, 16-word bursts.
    task automatic t_palette();
        int b;
        int pb;
        int bad = 0;
        burst_sel = 2'd2;
        b  = g_n;
        pb = p_n;
        load(32'h200);
        pulse_frame();
        cycles(300);
        chk(g_n - b == 5, "R6", "grant count palette+frame", 32'(g_n - b), 5);
        chk_grant(b, 32'h200, 4, "R1");
        chk_grant(b + 1, 32'h600, 6, "R6");
        chk_grant(b + 2, 32'h240, 4, "R6");
        chk_grant(b + 3, 32'h800, 16, "R4");
        chk_grant(b + 4, 32'h840, 4, "R4");
        chk(p_n - pb == 6, "R6", "palette word count", 32'(p_n - pb), 6);
        for (int i = 0; i < 6; i++) begin
            if (pb + i < 16)
                if (p_idx[pb + i] != 8'(i) || p_data[pb + i] != 32'hB000 + 32'(i)) bad++;
        end
        chk(bad == 0, "R6", "palette index and data", 32'(bad), 0);
        pop_and_compare(20, 32'hD000, "R6");
        chk(pix_avail == 1'b0, "R6", "no palette word in pixel FIFO", 32'(pix_avail), 0);
        b = g_n;
        cycles(50);
        chk(g_n == b, "R7", "no fetch before next frame start", 32'(g_n - b), 0);
        pulse_frame();
        cycles(300);
        chk_grant(b, 32'h200, 4, "R7");
    endtask

    // 40-word payload with 8-word bursts against a 32-word FIFO.
    task automatic t_backpressure();
        int b;
        burst_sel = 2'd1;
        b = g_n;
        load(32'h300);
        chk(pix_avail == 1'b0, "R2", "FIFO emptied by load", 32'(pix_avail), 0);
        pulse_frame();
        cycles(300);
        chk(g_n - b == 5, "R5", "grants while FIFO full", 32'(g_n - b), 5);
        chk_grant(b + 4, 32'hA00 + 3 * 32, 8, "R4");
        pop_and_compare(40, 32'hC000, "R5");
        chk(g_n - b == 6, "R5", "grants after draining", 32'(g_n - b), 6);
        chk(underrun == 1'b0, "R10", "no underrun while refilling", 32'(underrun), 0);
    endtask

    // Zero-length descriptor linked to the true-colour descriptor.
    task automatic t_zero_len();
        int b;
        burst_sel = 2'd0;
        b = g_n;
        load(32'h380);
        pulse_frame();
        cycles(100);
        chk(g_n - b == 1, "R9", "only the descriptor is read", 32'(g_n - b), 1);
        chk(pix_avail == 1'b0, "R9", "no payload for zero length", 32'(pix_avail), 0);
        pulse_frame();
        cycles(300);
        chk_grant(b + 1, 32'h100, 4, "R9");
    endtask

    // Underrun with and without protection; sticky flag and clear.
    task automatic t_underrun();
        logic [31:0] v;
        pop_and_compare(10, 32'hA000, "R3");
        underrun_protect = 1'b1;
        pop_word(v);
        chk(v == 32'hA009, "R10", "held pixel on protected underrun", v, 32'hA009);
        chk(underrun == 1'b1, "R11", "flag set on underrun", 32'(underrun), 1);
        underrun_protect = 1'b0;
        pop_word(v);
        chk(v == 32'h0, "R10", "zero pixel on unprotected underrun", v, 0);
        cycles(10);
        chk(underrun == 1'b1, "R11", "flag stays set", 32'(underrun), 1);
        load(32'h100);
        chk(underrun == 1'b0, "R11", "flag cleared by load", 32'(underrun), 0);
    endtask

    initial begin
        put_desc(32'h100, 32'h100, 32'h400, 32'd10);
        for (int i = 0; i < 10; i++) put(32'h400 + 4 * i, 32'hA000 + 32'(i));
        put_desc(32'h200, 32'h240, 32'h600, (32'd1 << 28) | 32'd6);
        put_desc(32'h240, 32'h200, 32'h800, 32'd20);
        for (int i = 0; i < 6; i++)  put(32'h600 + 4 * i, 32'hB000 + 32'(i));
        for (int i = 0; i < 20; i++) put(32'h800 + 4 * i, 32'hD000 + 32'(i));
        put_desc(32'h300, 32'h300, 32'hA00, 32'd40);
        for (int i = 0; i < 40; i++) put(32'hA00 + 4 * i, 32'hC000 + 32'(i));
        put_desc(32'h380, 32'h100, 32'hF00, 32'd0);

        cycles(5);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_self_link();
        t_palette();
        t_backpressure();
        t_zero_len();
        t_underrun();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule